// File: doc/BRIEF.md
# Two-Digit Cascaded Fractional Pulse-Rate Multiplier

This block turns a free-running clock into a thinned pulse stream whose average rate is a two-digit decimal fraction of the clock rate. It has two decade rate-multiplier digits, each programmed with a BCD code. A mode bit selects how the two digits combine. In sum mode the result is the fraction 0.N1N2. In product mode the result is (N1/10)·(N2/10).

In sum mode the upper digit advances on every clock. The lower digit advances only on the clock where the upper digit sits in its final decade state. That gives the lower digit one step per ten clocks, and the two streams are merged. In product mode the lower digit advances only on clocks where the upper digit emits a pulse, and the lower digit's pulses form the output.

A synchronous clear returns both decade counters to state 0 and resets the output register. The mode bit is captured only while clear is held. Pulse counts are defined over 100-clock windows that begin at the first clock after clear is released. The output is registered, so the pulse for decade state k appears one clock after that state is processed.

Top module: `rmul_cascade`

## Requirements
- R1: While `clr` is high, both counters are held at state 0. `pulse_out` is low on the clock after any clock that sampled `clr` high.
- R2: In sum mode (`mode_mul`=0 at clear), the first 100 output samples after clear release carry exactly 10·N1 + N2 pulses. For example, codes 9 and 4 give 94 pulses. The upper digit never pulses in its last decade state, so the two digit streams never coincide.
- R3: In product mode (`mode_mul`=1 at clear), the first 100 output samples after clear release carry exactly N1·N2 pulses. For example, codes 9 and 4 give 36 pulses.
- R4: A digit code of 0 contributes no pulses. When both codes are 0, `pulse_out` stays low.
- R5: Codes 10 to 15 on either rate input behave exactly as code 9.
- R6: `mode_mul` is sampled only on clocks where `clr` is high. Changing it after clear release has no effect on the pulse count.
- R7: The pulse pattern repeats every 100 clocks. A second consecutive 100-sample window gives the same count as the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock whose rate is multiplied |
| clr | input | 1 | Synchronous clear, active high; also the moment `mode_mul` is captured |
| mode_mul | input | 1 | 0 = sum of digit fractions, 1 = product of digit fractions |
| rate_hi | input | 4 | BCD code of the more significant digit (N1) |
| rate_lo | input | 4 | BCD code of the less significant digit (N2) |
| pulse_out | output | 1 | Registered output pulse stream, one clock wide per pulse |

## Verification
The bench builds the block with its default parameters: a radix of 10 and a 4-bit code width. With these defaults one output window is 100 clocks, and the exact sum and product counts can be compared against simple arithmetic on the two codes. The 4-bit code width makes the illegal codes 10 to 15 reachable, so the saturation rule can be exercised. Two back-to-back windows show that the combined counter period closes at 100 clocks.

// File: rtl/rmul_pkg.sv
package rmul_pkg;

    typedef struct packed {
        logic mode_mul;
        logic pulse;
    } top_state_t;

    // Decade state `state` of a digit programmed with `n` emits a pulse when
    // the shifted index crosses a multiple of radix; the shift places the
    // one guaranteed gap on the final state.
    function automatic logic pattern_hit(input int unsigned state,
                                         input int unsigned n,
                                         input int unsigned radix);
        int unsigned sh;
        sh = (state + 1) % radix;
        return (((sh + 1) * n) / radix) > ((sh * n) / radix);
    endfunction

endpackage

// File: rtl/rmul_digit.sv
module rmul_digit #(
    parameter int RADIX  = 10,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              adv,
    input  logic [CODE_W-1:0] code,
    output logic              fire,
    output logic              last
);
    import rmul_pkg::*;

    localparam int CNT_W = $clog2(RADIX);
    localparam int MAX_N = RADIX - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } dig_state_t;

    dig_state_t st_d, st_q;
    logic [CODE_W-1:0] n_sat;
    logic hit;

    always_comb begin
        n_sat = code;
        if (int'(code) > MAX_N) begin
            n_sat = CODE_W'(MAX_N);
        end
        hit  = pattern_hit(int'(st_q.cnt), int'(n_sat), RADIX);
        last = (int'(st_q.cnt) == MAX_N);
        fire = adv && hit;

        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (adv) begin
            if (last) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/rmul_route.sv
module rmul_route (
    input  logic mode_mul,
    input  logic up_fire,
    input  logic up_last,
    input  logic lo_fire,
    output logic lo_adv,
    output logic merged
);
    always_comb begin
        if (mode_mul) begin
            lo_adv = up_fire;
            merged = lo_fire;
        end else begin
            lo_adv = up_last;
            merged = up_fire | lo_fire;
        end
    end
endmodule

// File: rtl/rmul_cascade.sv
module rmul_cascade #(
    parameter int RADIX  = 10,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              mode_mul,
    input  logic [CODE_W-1:0] rate_hi,
    input  logic [CODE_W-1:0] rate_lo,
    output logic              pulse_out
);
    import rmul_pkg::*;

    localparam int NDIG = 2;

    logic [NDIG-1:0] dig_adv;
    logic [NDIG-1:0] dig_fire;
    logic [NDIG-1:0] dig_last;
    logic [CODE_W-1:0] dig_code [NDIG];
    logic lo_adv;
    logic merged;

    top_state_t top_d, top_q;

    assign dig_code[0] = rate_hi;
    assign dig_code[1] = rate_lo;
    assign dig_adv[0]  = 1'b1;
    assign dig_adv[1]  = lo_adv;

    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        rmul_digit #(
            .RADIX (RADIX),
            .CODE_W(CODE_W)
        ) digit_i (
            .clk (clk),
            .clr (clr),
            .adv (dig_adv[g]),
            .code(dig_code[g]),
            .fire(dig_fire[g]),
            .last(dig_last[g])
        );
    end

    rmul_route route_i (
        .mode_mul(top_q.mode_mul),
        .up_fire (dig_fire[0]),
        .up_last (dig_last[0]),
        .lo_fire (dig_fire[1]),
        .lo_adv  (lo_adv),
        .merged  (merged)
    );

    always_comb begin
        top_d = top_q;
        if (clr) begin
            top_d.mode_mul = mode_mul;
            top_d.pulse    = 1'b0;
        end else begin
            top_d.pulse    = merged;
        end
    end

    always_ff @(posedge clk) begin
        top_q <= top_d;
    end

    assign pulse_out = top_q.pulse;

endmodule

// File: rtl/rmul_cascade_chk.sv
module rmul_cascade_chk #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              clr,
    input logic [CODE_W-1:0] rate_hi,
    input logic [CODE_W-1:0] rate_lo,
    input logic              pulse_out,
    input logic              mode_q,
    input logic [1:0]        fire_v,
    input logic [1:0]        last_v
);
    a_r1_clear_quiet: assert property (@(posedge clk) clr |=> !pulse_out);

    a_r2_gap_at_last: assert property (@(posedge clk) disable iff (clr)
        last_v[0] |-> !fire_v[0]);

    a_r2_no_overlap: assert property (@(posedge clk) disable iff (clr)
        !mode_q |-> !(fire_v[0] && fire_v[1]));

    a_r3_lower_needs_upper: assert property (@(posedge clk) disable iff (clr)
        (mode_q && fire_v[1]) |-> fire_v[0]);

    a_r4_zero_codes: assert property (@(posedge clk) disable iff (clr)
        (rate_hi == '0 && rate_lo == '0) |=> !pulse_out);

    a_r6_mode_hold: assert property (@(posedge clk) disable iff (clr)
        1'b1 |=> $stable(mode_q));
endmodule

bind rmul_cascade rmul_cascade_chk #(.CODE_W(CODE_W)) chk_i (
    .clk      (clk),
    .clr      (clr),
    .rate_hi  (rate_hi),
    .rate_lo  (rate_lo),
    .pulse_out(pulse_out),
    .mode_q   (top_q.mode_mul),
    .fire_v   (dig_fire),
    .last_v   (dig_last)
);

// File: tb/rmul_cascade_tb_top.sv
module rmul_cascade_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic clr = 1'b1;
    logic mode_mul = 1'b0;
    logic [3:0] rate_hi = '0;
    logic [3:0] rate_lo = '0;
    logic pulse_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rmul_cascade dut_i (
        .clk      (clk),
        .clr      (clr),
        .mode_mul (mode_mul),
        .rate_hi  (rate_hi),
        .rate_lo  (rate_lo),
        .pulse_out(pulse_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_clear(input logic m, input logic [3:0] hi, input logic [3:0] lo);
        @(negedge clk);
        clr = 1'b1; mode_mul = m; rate_hi = hi; rate_lo = lo;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R1 out low under clear", int'(pulse_out), 0);
    endtask

    task automatic count_window(output int cnt);
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk);
            @(negedge clk);
            cnt += int'(pulse_out);
        end
    endtask

    task automatic run_window(input string req, input logic m,
                              input logic [3:0] hi, input logic [3:0] lo, input int exp);
        int cnt;
        do_clear(m, hi, lo);
        clr = 1'b0;
        count_window(cnt);
        check(req, cnt, exp);
    endtask

    task automatic mode_flip_test;
        int cnt;
        do_clear(1'b0, 4'd9, 4'd4);
        clr = 1'b0;
        mode_mul = 1'b1;
        count_window(cnt);
        check("R6 mode change after clear ignored", cnt, 94);
        mode_mul = 1'b0;
    endtask

    task automatic repeat_test;
        int c1, c2;
        do_clear(1'b0, 4'd3, 4'd7);
        clr = 1'b0;
        count_window(c1);
        count_window(c2);
        check("R7 first window", c1, 37);
        check("R7 second window", c2, 37);
    endtask

    task automatic zero_test;
        int cnt;
        do_clear(1'b1, 4'd0, 4'd0);
        clr = 1'b0;
        count_window(cnt);
        check("R4 both zero product", cnt, 0);
    endtask

    initial begin
        run_window("R2 sum 9,4", 1'b0, 4'd9, 4'd4, 94);
        run_window("R2 sum 9,9", 1'b0, 4'd9, 4'd9, 99);
        run_window("R2 sum 0,7", 1'b0, 4'd0, 4'd7, 7);
        run_window("R4 sum 5,0", 1'b0, 4'd5, 4'd0, 50);
        run_window("R4 sum 0,0", 1'b0, 4'd0, 4'd0, 0);
        run_window("R3 product 9,4", 1'b1, 4'd9, 4'd4, 36);
        run_window("R3 product 7,3", 1'b1, 4'd7, 4'd3, 21);
        run_window("R3 product 9,9", 1'b1, 4'd9, 4'd9, 81);
        run_window("R4 product 0,9", 1'b1, 4'd0, 4'd9, 0);
        run_window("R5 sum 12,4", 1'b0, 4'd12, 4'd4, 94);
        run_window("R5 product 15,15", 1'b1, 4'd15, 4'd15, 81);
        run_window("R5 sum 2,10", 1'b0, 4'd2, 4'd10, 29);
        zero_test();
        mode_flip_test();
        repeat_test();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule